// File: doc/BRIEF.md
# Start-Gated Serial Receiver

This block receives 8N1 asynchronous serial characters: one start bit (low), eight data bits sent least significant bit first, and one stop bit (high). It runs from a single fast clock at sixteen times the bit rate. A two-flop synchroniser cleans up the line and feeds a falling-edge detector. The edge sets a start latch. While that latch is clear, the latch keeps the sixteen-count bit divider and the bit index in reset. A start edge therefore re-phases all bit timing within one fast clock, and this happens again on every character.

Once released, the divider samples each bit near its middle and shifts data bits into a shift register. At the mid-point of the stop bit it copies the byte into a holding register, pulses a data-valid strobe for one cycle, updates the framing-error flag and clears the start latch. The receiver then waits for the next falling edge. If the line is high again at the middle of the start bit, the event is treated as a glitch and dropped. A receiver that locked onto a data edge in mid-stream is back in alignment after any idle gap longer than one character.

Top module: `start_gated_rx`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `data_o` is 0x00, `valid_o` is 0 and `frame_err_o` is 0.
- R2: A frame with 16 clock periods per bit is decoded into `data_o`. The frame is a low start bit, then eight data bits with the first bit on the line going to `data_o[0]`, then a stop bit.
- R3: `valid_o` is high for exactly one cycle per accepted frame. It rises at the 155th rising clock edge, counting as the first edge the one that first samples `rx_i` low at the start of the frame.
- R4: `frame_err_o` takes the inverse of the sampled stop bit (1 when the stop bit is low) in the same cycle as `valid_o`, and keeps that value until the next `valid_o`.
- R5: `data_o` keeps the previous byte while the next frame is shifting in, and changes only in a cycle where `valid_o` is high.
- R6: A low pulse on `rx_i` that has ended before the middle of the start bit (4 clocks long here) produces no `valid_o` and leaves the outputs unchanged. The next proper frame is decoded correctly.
- R7: Falling edges on `rx_i` inside a frame that has been accepted do not restart bit timing. Bytes with alternating bits (0x55, 0xAA) decode correctly.
- R8: The start latch re-arms at the middle of the stop bit. A new start edge 12 clocks into the previous stop bit, or back-to-back frames with no idle time, are decoded correctly.
- R9: After the receiver locks onto a data-bit edge in mid-stream, an idle-high gap longer than one frame brings it back into alignment, and the next frame decodes correctly.
- R10: Asserting `rst_ni` low in the middle of a frame abandons that frame. Outputs return to their reset values, and the next frame after reset decodes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock, 16 times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | 8 | Last received byte (holding register) |
| valid_o | output | 1 | One-cycle strobe when `data_o` is updated |
| frame_err_o | output | 1 | Set when the last frame's stop bit was sampled low |

## Verification
A vector table sends all-zero, all-one, alternating and asymmetric bytes, with good and bad stop bits. These separate bit-order and shift-count errors from sample-phase errors, and the exact strobe cycle shows whether the divider was truly held until the edge. Back-to-back frames with a shortened stop bit show whether the latch re-arms at mid-stop instead of after a full stop bit. A short low pulse tells a real start from a glitch. A stream joined in its middle and then followed by an idle gap shows that the receiver recovers its alignment. A reset in the middle of a frame shows that a partly received frame is thrown away.

// File: rtl/sgrx_pkg.sv
`timescale 1ns/1ps
package sgrx_pkg;
  // start + data + stop
  function automatic int unsigned frame_len(input int unsigned data_bits);
    return data_bits + 2;
  endfunction
endpackage

// File: rtl/sgrx_sync.sv
`timescale 1ns/1ps
module sgrx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign q_o    = pipe_q[STAGES-1];
  assign fall_o = prev_q & ~pipe_q[STAGES-1];
endmodule

// File: rtl/sgrx_start_latch.sv
`timescale 1ns/1ps
module sgrx_start_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic active_o
);
  logic active_q;

  // clear wins: end of frame or rejected start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_q <= 1'b0;
    else if (clr_i)   active_q <= 1'b0;
    else if (set_i)   active_q <= 1'b1;
  end

  assign active_o = active_q;
endmodule

// File: rtl/sgrx_bit_timer.sv
`timescale 1ns/1ps
module sgrx_bit_timer #(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned FRAME_BITS = 10,
  localparam int unsigned CW   = $clog2(OVERSAMPLE),
  localparam int unsigned IW   = $clog2(FRAME_BITS),
  localparam int unsigned HALF = OVERSAMPLE / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic          smp_o,
  output logic [IW-1:0] idx_o
);
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;

  // held in reset whenever the start latch is clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (cnt_q == CW'(OVERSAMPLE-1)) begin
      cnt_q <= '0;
      idx_q <= idx_q + IW'(1);
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign smp_o = run_i && (cnt_q == CW'(HALF-1));
  assign idx_o = idx_q;
endmodule

// File: rtl/sgrx_frame.sv
`timescale 1ns/1ps
module sgrx_frame #(
  parameter int unsigned DATA_BITS  = 8,
  parameter int unsigned FRAME_BITS = 10,
  localparam int unsigned IW = $clog2(FRAME_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_i,
  input  logic [IW-1:0]        idx_i,
  input  logic                 bit_i,
  output logic                 done_o,
  output logic                 glitch_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 ferr_o
);
  logic [DATA_BITS-1:0] shift_q, hold_q;
  logic                 valid_q, ferr_q;
  logic                 is_start, is_stop;

  assign is_start = (idx_i == '0);
  assign is_stop  = (idx_i == IW'(FRAME_BITS-1));
  assign done_o   = smp_i && is_stop;
  assign glitch_o = smp_i && is_start && bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      hold_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (smp_i && !is_start && !is_stop)
        shift_q <= {bit_i, shift_q[DATA_BITS-1:1]};  // LSB first
      if (done_o) begin
        hold_q  <= shift_q;
        valid_q <= 1'b1;
        ferr_q  <= ~bit_i;
      end
    end
  end

  assign data_o  = hold_q;
  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;
endmodule

// File: rtl/start_gated_rx.sv
`timescale 1ns/1ps
module start_gated_rx #(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned FRAME_BITS = sgrx_pkg::frame_len(DATA_BITS),
  localparam int unsigned IW         = $clog2(FRAME_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 frame_err_o
);
  logic          rx_s, rx_fall;
  logic          latch_active;
  logic          smp;
  logic [IW-1:0] bit_idx;
  logic          frame_done, start_glitch;

  sgrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (rx_i),
    .q_o (rx_s), .fall_o (rx_fall)
  );

  sgrx_start_latch u_latch (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (rx_fall), .clr_i (frame_done | start_glitch),
    .active_o (latch_active)
  );

  sgrx_bit_timer #(.OVERSAMPLE(OVERSAMPLE), .FRAME_BITS(FRAME_BITS)) u_timer (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (latch_active),
    .smp_o (smp), .idx_o (bit_idx)
  );

  sgrx_frame #(.DATA_BITS(DATA_BITS), .FRAME_BITS(FRAME_BITS)) u_frame (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .smp_i (smp), .idx_i (bit_idx), .bit_i (rx_s),
    .done_o (frame_done), .glitch_o (start_glitch),
    .data_o (data_o), .valid_o (valid_o), .ferr_o (frame_err_o)
  );
endmodule

// File: rtl/sgrx_chk.sv
`timescale 1ns/1ps
module sgrx_chk #(
  parameter int unsigned DATA_BITS  = 8,
  parameter int unsigned FRAME_BITS = 10,
  localparam int unsigned IW = $clog2(FRAME_BITS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [DATA_BITS-1:0] data_o,
  input logic                 valid_o,
  input logic                 frame_err_o,
  input logic                 active,
  input logic [IW-1:0]        bit_idx
);
  assert_valid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_valid_ends_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $fell(active));

  assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> valid_o);

  assert_ferr_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_err_o) |-> valid_o);

  assert_timer_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (bit_idx == '0));

  assert_idx_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_idx <= IW'(FRAME_BITS-1));
endmodule

bind start_gated_rx sgrx_chk #(.DATA_BITS(DATA_BITS), .FRAME_BITS(FRAME_BITS)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .data_o (data_o), .valid_o (valid_o),
  .frame_err_o (frame_err_o), .active (latch_active), .bit_idx (bit_idx)
);

// File: tb/sim_start_gated_rx.sv
`timescale 1ns/1ps
module sim_start_gated_rx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic [7:0] data_o;
  logic       valid_o, frame_err_o;

  int errors = 0;
  int checks = 0;
  int pulses, pulse_at;
  logic early_change;

  // entry: {data, stop level, stop length in clocks}
  localparam logic [16:0] VEC [8] = '{
    {8'h00, 1'b1, 8'd16}, {8'hFF, 1'b1, 8'd16}, {8'h55, 1'b1, 8'd16},
    {8'hAA, 1'b1, 8'd16}, {8'h3C, 1'b1, 8'd12}, {8'h81, 1'b1, 8'd16},
    {8'hC6, 1'b0, 8'd16}, {8'h7E, 1'b1, 8'd16}
  };

  always #4 clk_i = ~clk_i;

  start_gated_rx u0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .rx_i (rx_i),
    .data_o (data_o), .valid_o (valid_o), .frame_err_o (frame_err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives one frame from negedge 0; watches outputs each negedge before driving
  task automatic send_frame(input logic [7:0] d, input logic stop, input int stop_len,
                            input int idle);
    logic [7:0] prev;
    prev = data_o;
    pulses = 0; pulse_at = -1; early_change = 1'b0;
    for (int i = 0; i < 144 + stop_len + idle; i++) begin
      @(negedge clk_i);
      if (valid_o) begin
        pulses++;
        if (pulse_at < 0) pulse_at = i;
      end else if (pulse_at < 0 && data_o != prev) begin
        early_change = 1'b1;
      end
      if (i < 16)                 rx_i = 1'b0;
      else if (i < 144)           rx_i = d[(i-16)/16];
      else if (i < 144 + stop_len) rx_i = stop;
      else                        rx_i = 1'b1;
    end
  endtask

  task automatic idle_watch(input int n);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (valid_o) pulses++;
      rx_i = 1'b1;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(data_o == 8'h00 && !valid_o && !frame_err_o, "R1 in reset",
          {data_o, valid_o, frame_err_o}, 0);
    rst_ni = 1'b1;
    idle_watch(20);
    check(data_o == 8'h00 && pulses == 0 && !frame_err_o, "R1 after release",
          {data_o, frame_err_o}, 0);

    // table walk
    foreach (VEC[k]) begin
      send_frame(VEC[k][16:9], VEC[k][8], int'(VEC[k][7:0]), VEC[k][8] ? 0 : 20);
      check(data_o == VEC[k][16:9], "R2 data", data_o, VEC[k][16:9]);
      check(pulses == 1, "R3 one pulse", pulses, 1);
      check(pulse_at == 155, "R3 strobe cycle", pulse_at, 155);
      check(frame_err_o == ~VEC[k][8], "R4 stop flag", frame_err_o, ~VEC[k][8]);
      check(!early_change, "R5 hold stable", early_change, 0);
      if (VEC[k][16:9] == 8'h55 || VEC[k][16:9] == 8'hAA)
        check(data_o == VEC[k][16:9], "R7 inner edges", data_o, VEC[k][16:9]);
    end

    // R4: flag clears on next good frame (last vector good after error vector)
    check(frame_err_o == 1'b0, "R4 flag cleared", frame_err_o, 0);

    // R6: short low pulse
    for (int i = 0; i < 4; i++) begin @(negedge clk_i); rx_i = 1'b0; end
    idle_watch(200);
    check(pulses == 0, "R6 no strobe", pulses, 0);
    check(data_o == 8'h7E, "R6 data unchanged", data_o, 8'h7E);
    send_frame(8'h5A, 1'b1, 16, 0);
    check(data_o == 8'h5A && pulses == 1, "R6 next frame", data_o, 8'h5A);

    // R8: start edge 12 clocks into stop, back to back
    send_frame(8'hE7, 1'b1, 12, 0);
    check(data_o == 8'hE7, "R8 first", data_o, 8'hE7);
    send_frame(8'h18, 1'b1, 16, 0);
    check(data_o == 8'h18 && pulse_at == 155, "R8 re-armed", data_o, 8'h18);

    // R9: join mid-stream on a data edge, then idle gap
    for (int i = 0; i < 96; i++) begin
      @(negedge clk_i);
      rx_i = ((i / 16) % 3 == 0) ? 1'b0 : 1'b1;
    end
    idle_watch(200);
    send_frame(8'h96, 1'b1, 16, 0);
    check(data_o == 8'h96 && pulse_at == 155, "R9 realigned", data_o, 8'h96);

    // R10: reset in mid-frame
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      rx_i = (i < 16) ? 1'b0 : 1'b1;
    end
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(data_o == 8'h00 && !valid_o && !frame_err_o, "R10 reset values",
          {data_o, valid_o, frame_err_o}, 0);
    rst_ni = 1'b1;
    idle_watch(200);
    check(pulses == 0, "R10 frame dropped", pulses, 0);
    send_frame(8'h3A, 1'b1, 16, 0);
    check(data_o == 8'h3A && pulses == 1, "R10 next frame", data_o, 8'h3A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule